// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on a single asynchronous serial line. Software writes a character into a one-entry holding register. When the shift stage is free, or when the stop bit of the current character ends, the character moves into the shift stage. The line then carries a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit and a high stop bit. Each bit lasts sixteen pulses of an external oversampling tick. Because of the holding register, software can queue the next character while the current one is still going out, and the two leave back to back.

Two flags tell software what the block can accept. The ready flag means the holding register can take a character. The empty flag means the holding register and the shift stage are both empty. Enable and disable commands gate the whole path. While disabled, both flags are low, the line idles high, and any write is dropped. A disable that arrives in the middle of a character stops it at once and discards any character that is waiting.

Top module: `serial_tx_dbuf`

## Requirements
- R1: After reset the transmitter is disabled. `txd` is high and `tx_ready` and `tx_empty` are low, and this holds for as long as it stays disabled.
- R2: A one-cycle `en_cmd` pulse enables the transmitter, and `tx_ready` is high in the following cycle. When `en_cmd` and `dis_cmd` arrive together, the disable wins.
- R3: A `wr_stb` pulse loads `wr_data` only while `tx_ready` is high, and `tx_ready` is then low in the next cycle. A write made while disabled, or while the holding register is full, is dropped and never sent.
- R4: When the shift stage is idle, a held character enters it one cycle after the write. In that same cycle `tx_ready` returns high and `txd` drops to start the frame.
- R5: A frame is a start bit at 0, then N data bits with the least significant bit first, where N = 5 + `cfg_word[1:0]`. Every bit lasts exactly 16 `tick16` pulses, so clock cycles without a tick do not count.
- R6: When `cfg_word[2]` is 1, one parity bit follows the last data bit. `cfg_word[4:3]` selects it: 0 gives even parity, 1 gives odd parity, 2 gives a constant 0 and 3 gives a constant 1. The configuration is sampled when the character enters the shift stage.
- R7: Each frame ends with one high stop bit. If a character is waiting when the stop bit ends, its start bit begins on the next cycle with no idle time.
- R8: `tx_empty` is high only while the block is enabled with both the holding register and the shift stage empty. It rises in the cycle right after the stop bit of the last queued character ends.
- R9: `dis_cmd` takes effect in the next cycle. The frame in flight is cut short, `txd` returns high, both flags go low, and a waiting character is discarded, so it is not sent after a later enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit time |
| en_cmd | input | 1 | Enable command pulse |
| dis_cmd | input | 1 | Disable command pulse, takes priority |
| cfg_word | input | 5 | [1:0] length code, [2] parity on, [4:3] parity kind |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Holding register and shift stage both empty |

## Verification
The embedded assertions check several rules in every cycle. The line stays quiet and both flags stay low while the block is disabled. A disable silences everything one cycle later. Empty never shows without ready. A write that is accepted drops ready. A waiting character always follows a stop bit directly. The tick counter holds its value whenever no tick arrives.

Other behaviour can only be shown by the bench scenarios. These cover the exact bit values on the wire for every length and parity setting, the absence of a gap between queued characters, and the cycle in which empty rises. They also show that characters written while disabled, or into a full holding register, never appear, and that a bit's width follows the tick and not the clock.

// File: rtl/stx_pkg.sv
// Shared types for the serial transmitter.
// Assumes the configuration word layout given in the brief (5 bits).
package stx_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_PAR,
        FS_STOP
    } frame_state_e;

    typedef enum logic [1:0] {
        PM_EVEN = 2'd0,
        PM_ODD  = 2'd1,
        PM_ZERO = 2'd2,
        PM_ONE  = 2'd3
    } par_mode_e;

    // Packed MSB first: kind [4:3], parity on [2], length code [1:0].
    typedef struct packed {
        par_mode_e  mode;
        logic       par_en;
        logic [1:0] len_code;
    } tx_cfg_t;

    // Turns the XOR of the data bits into the parity bit that goes on the line.
    function automatic logic parity_bit(logic ones_odd, par_mode_e m);
        case (m)
            PM_EVEN: return ones_odd;
            PM_ODD:  return ~ones_odd;
            PM_ZERO: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/stx_bitclk.sv
// Bit timer: counts oversampling ticks and flags the last tick of each bit.
// Assumes clr is pulsed when a frame starts, so the first bit has a full width.
module stx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    logic [CW-1:0] cnt;

    assign bit_end = tick && (cnt == LAST);

    // Tick counter that wraps once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // R5: only ticks advance the bit timer
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt));
    // R5: a bit boundary restarts the count
    a_r5_wrap_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_end && !clr) |=> (cnt == '0));

endmodule

// File: rtl/stx_hold.sv
// Holding register: one-entry buffer between software and the shift stage.
// Assumes run is low whenever the transmitter is disabled or being disabled.
module stx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              en_q,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data,
    output logic              ready
);
    logic accept;

    assign accept = wr_stb && run && !hold_valid;
    assign ready  = en_q && !hold_valid;

    // Load on accepted write, free on transfer, flush while not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (!run) begin
            hold_valid <= 1'b0;
        end else if (accept) begin
            hold_valid <= 1'b1;
            hold_data  <= wr_data;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

    // R3: an accepted write drops ready
    a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ready) |=> !ready);
    // R3: an accepted write fills the register
    a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && ready && run) |=> hold_valid);
    // R4: a transfer frees the register
    a_r4_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !hold_valid);

endmodule

// File: rtl/stx_frame.sv
// Frame sequencer: start bit, data bits with the LSB first, optional parity, stop bit.
// Assumes bit_end marks the last tick of the current bit and that take
// clears the bit timer in the same cycle.
module stx_frame
    import stx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bit_end,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  tx_cfg_t           cfg,
    output logic              take,
    output logic              busy,
    output logic              txd
);
    localparam int MIN_LEN = DATA_W - 3;
    localparam int CNT_W   = $clog2(DATA_W + 1);

    frame_state_e      state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  left;
    logic              par_q;
    logic              pen_q;
    logic [CNT_W-1:0]  n_len;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;
    logic              ld_par;
    logic              stop_end;

    assign stop_end = (state == FS_STOP) && bit_end;
    assign take     = run && hold_valid && ((state == FS_IDLE) || stop_end);
    assign busy     = (state != FS_IDLE);

    // Data length, data mask and parity of the character about to load.
    always_comb begin
        n_len = CNT_W'(MIN_LEN) + CNT_W'(cfg.len_code);
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < int'(n_len));
        end
        masked = hold_data & mask;
        ld_par = parity_bit(^masked, cfg.mode);
    end

    // Frame state machine with its shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            shreg <= '0;
            left  <= '0;
            par_q <= 1'b0;
            pen_q <= 1'b0;
        end else if (!run) begin
            state <= FS_IDLE;
        end else if (take) begin
            state <= FS_START;
            shreg <= masked;
            left  <= n_len;
            par_q <= ld_par;
            pen_q <= cfg.par_en;
        end else if (bit_end) begin
            case (state)
                FS_START: state <= FS_DATA;
                FS_DATA: begin
                    shreg <= {1'b0, shreg[DATA_W-1:1]};
                    left  <= left - 1'b1;
                    if (left == CNT_W'(1)) state <= pen_q ? FS_PAR : FS_STOP;
                end
                FS_PAR:  state <= FS_STOP;
                FS_STOP: state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Line level for the current bit.
    always_comb begin
        case (state)
            FS_START: txd = 1'b0;
            FS_DATA:  txd = shreg[0];
            FS_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    // R7: a waiting character follows the stop bit with no gap
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_end && hold_valid && run) |=> (state == FS_START));
    // R5: the data bit count stays within the configured range
    a_r5_left_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_DATA) |-> (left != '0 && int'(left) <= DATA_W));
    // R6: a parity bit appears only when parity was enabled at load
    a_r6_parity_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_PAR) |-> pen_q);
    // R5: the start bit is followed by data
    a_r5_start_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_START && bit_end && run) |=> (state == FS_DATA));

endmodule

// File: rtl/serial_tx_dbuf.sv
// Double-buffered serial transmitter top: enable control, flags and wiring.
// Assumes tick16 is a one-cycle pulse at 16 times the bit rate.
module serial_tx_dbuf
    import stx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              en_cmd,
    input  logic              dis_cmd,
    input  logic [4:0]        cfg_word,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty
);
    logic              enabled_q;
    logic              run;
    logic              take;
    logic              busy;
    logic              bit_end;
    logic              hold_valid;
    logic [DATA_W-1:0] hold_data;
    tx_cfg_t           cfg;

    assign cfg      = tx_cfg_t'(cfg_word);
    assign run      = enabled_q && !dis_cmd;
    assign tx_empty = enabled_q && !hold_valid && !busy;

    // Enable state; disable takes priority over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       enabled_q <= 1'b0;
        else if (dis_cmd) enabled_q <= 1'b0;
        else if (en_cmd)  enabled_q <= 1'b1;
    end

    stx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .en_q       (enabled_q),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .take       (take),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .ready      (tx_ready)
    );

    stx_bitclk #(.OVS(OVS)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take),
        .tick    (tick16),
        .bit_end (bit_end)
    );

    stx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .bit_end    (bit_end),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .cfg        (cfg),
        .take       (take),
        .busy       (busy),
        .txd        (txd)
    );

    // R1: quiet line and low flags while disabled
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_q |-> (txd && !tx_ready && !tx_empty));
    // R2: enabling from the disabled state raises ready next cycle
    a_r2_ready_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && !dis_cmd && !enabled_q) |=> tx_ready);
    // R8: empty implies the holding register is free
    a_r8_empty_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);
    // R9: a disable silences the line and drops both flags
    a_r9_disable_silences: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> (txd && !tx_ready && !tx_empty));

endmodule

// File: tb/sim_serial_tx_dbuf.sv
module sim_serial_tx_dbuf;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       en_cmd = 1'b0;
    logic       dis_cmd = 1'b0;
    logic [4:0] cfg_word = 5'd0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, tx_ready, tx_empty;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int tdiv = 1;
    int tph = 0;
    bit done = 1'b0;

    serial_tx_dbuf u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .en_cmd(en_cmd),
        .dis_cmd(dis_cmd), .cfg_word(cfg_word), .wr_stb(wr_stb),
        .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Tick pulse: one every tdiv cycles, changed away from the active edge.
    always @(negedge clk) begin
        tph = (tph + 1 >= tdiv) ? 0 : tph + 1;
        tick16 <= (tph == 0);
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_until(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drive_wr(logic [7:0] d);
        wr_data = d;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic pulse_en();
        en_cmd = 1'b1;
        @(negedge clk);
        en_cmd = 1'b0;
    endtask

    task automatic pulse_dis();
        dis_cmd = 1'b1;
        @(negedge clk);
        dis_cmd = 1'b0;
    endtask

    // Expected line bits of one frame, computed from the requirements.
    task automatic build(logic [7:0] d, logic [4:0] c, output logic [11:0] b, output int f);
        int  n;
        bit  p;
        n = 5 + int'(c[1:0]);
        b = '0;
        p = 1'b0;
        b[0] = 1'b0;
        for (int i = 0; i < n; i++) begin
            b[1 + i] = d[i];
            p = p ^ d[i];
        end
        f = 1 + n;
        if (c[2]) begin
            case (c[4:3])
                2'd0: b[f] = p;
                2'd1: b[f] = ~p;
                2'd2: b[f] = 1'b0;
                default: b[f] = 1'b1;
            endcase
            f++;
        end
        b[f] = 1'b1;
        f++;
    endtask

    task automatic check_bits(int t0, logic [11:0] b, int f, bit pen);
        for (int j = 0; j < f; j++) begin
            wait_until(t0 + 8 + 16 * j);
            if (j == f - 1)            chk("R7", "stop bit", int'(txd), int'(b[j]));
            else if (pen && j == f - 2) chk("R6", "parity bit", int'(txd), int'(b[j]));
            else                        chk("R5", "frame bit", int'(txd), int'(b[j]));
        end
    endtask

    // One character through an idle transmitter with full timing checks.
    task automatic run_frame(logic [7:0] d, logic [4:0] c);
        logic [11:0] b;
        int f;
        int t0;
        build(d, c, b, f);
        cfg_word = c;
        drive_wr(d);
        chk("R3", "ready after write", int'(tx_ready), 0);
        @(negedge clk);
        t0 = cyc;
        chk("R4", "ready after transfer", int'(tx_ready), 1);
        chk("R4", "start on transfer", int'(txd), 0);
        check_bits(t0, b, f, c[2]);
        wait_until(t0 + 16 * f - 1);
        chk("R8", "empty during stop", int'(tx_empty), 0);
        wait_until(t0 + 16 * f);
        chk("R8", "empty after stop", int'(tx_empty), 1);
        chk("R7", "idle after stop", int'(txd), 1);
    endtask

    task automatic count_low(int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            if (!txd) lows++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [7:0] pats [8];
        logic [11:0] ba, bb;
        int fa, fb, t0, lows, hi;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hD2;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "txd after reset", int'(txd), 1);
        chk("R1", "ready after reset", int'(tx_ready), 0);
        chk("R1", "empty after reset", int'(tx_empty), 0);

        // R3: a write while disabled is dropped
        drive_wr(8'h55);
        chk("R1", "ready while disabled", int'(tx_ready), 0);
        pulse_en();
        chk("R2", "ready on enable", int'(tx_ready), 1);
        chk("R8", "empty on enable", int'(tx_empty), 1);
        count_low(300, lows);
        chk("R3", "low cycles after disabled write", lows, 0);

        // Sweep: every length, every parity setting, several data patterns.
        for (int len = 0; len < 4; len++) begin
            for (int pc = 0; pc < 5; pc++) begin
                for (int k = 0; k < 8; k++) begin
                    logic [4:0] c;
                    c[1:0] = 2'(len);
                    c[2]   = (pc != 0);
                    c[4:3] = (pc == 0) ? 2'd0 : 2'(pc - 1);
                    run_frame(pats[k] ^ 8'(len * 37 + pc * 11), c);
                end
            end
        end

        // R7: back to back, with a third write into a full holding register
        cfg_word = 5'b01_1_11;
        build(8'hC3, cfg_word, ba, fa);
        build(8'h3E, cfg_word, bb, fb);
        drive_wr(8'hC3);
        @(negedge clk);
        t0 = cyc;
        chk("R4", "start of first", int'(txd), 0);
        drive_wr(8'h3E);
        chk("R3", "ready with full holding", int'(tx_ready), 0);
        drive_wr(8'h99);
        check_bits(t0, ba, fa, 1'b1);
        wait_until(t0 + 16 * fa);
        chk("R7", "no gap start", int'(txd), 0);
        chk("R8", "empty between chars", int'(tx_empty), 0);
        chk("R4", "ready after second transfer", int'(tx_ready), 1);
        check_bits(t0 + 16 * fa, bb, fb, 1'b1);
        wait_until(t0 + 16 * (fa + fb) - 1);
        chk("R8", "empty in last stop", int'(tx_empty), 0);
        wait_until(t0 + 16 * (fa + fb));
        chk("R3", "dropped write not sent (empty)", int'(tx_empty), 1);
        count_low(300, lows);
        chk("R3", "dropped write not sent (line)", lows, 0);

        // R5: bit width counts ticks, not clocks
        tdiv = 2;
        cfg_word = 5'b00_0_00;
        drive_wr(8'h02);
        while (txd) @(negedge clk);
        while (!txd) @(negedge clk);
        hi = 0;
        while (txd) begin hi++; @(negedge clk); end
        chk("R5", "bit width at half tick rate", hi, 32);
        while (!tx_empty) @(negedge clk);
        tdiv = 1;

        // R9: disable in mid frame with a character waiting
        cfg_word = 5'b00_0_11;
        drive_wr(8'h00);
        @(negedge clk);
        drive_wr(8'hFF);
        repeat (40) @(negedge clk);
        chk("R9", "line low before disable", int'(txd), 0);
        pulse_dis();
        chk("R9", "txd after disable", int'(txd), 1);
        chk("R9", "ready after disable", int'(tx_ready), 0);
        chk("R9", "empty after disable", int'(tx_empty), 0);
        pulse_en();
        chk("R2", "ready on re-enable", int'(tx_ready), 1);
        chk("R9", "empty on re-enable", int'(tx_empty), 1);
        count_low(400, lows);
        chk("R9", "discarded char not sent", lows, 0);

        // R2: disable wins over a simultaneous enable
        en_cmd = 1'b1;
        dis_cmd = 1'b1;
        @(negedge clk);
        en_cmd = 1'b0;
        dis_cmd = 1'b0;
        chk("R2", "ready after both commands", int'(tx_ready), 0);
        chk("R2", "empty after both commands", int'(tx_empty), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule